// File: doc/BRIEF.md
# Adjustable-Top Timer with Complementary Dead-Band PWM

This block is an 8-bit up-counter with three compare registers. It can run in two modes. In free-running mode the counter wraps from 0xFF to 0x00. Each wrap and each match against compare registers A and B raises a status flag. In PWM mode, compare register C sets the top of the count, and the period becomes C+1 steps. Channels A and B each drive a pair of outputs: a true output and its complement. A programmable dead band keeps the two outputs of a pair apart.

The counter steps only on clock cycles where the external prescaler's `tick` input is high. Software reaches the block through one register port with a single-cycle write and a combinational read. The register addresses are:

| Address | Register |
|---|---|
| 0 | counter |
| 1 | compare A |
| 2 | compare B |
| 3 | top (compare C) |
| 4 | control |
| 5 | flags |
| 6 | mask |

The control register holds the mode in bit 0 (1 selects PWM) and the dead time in bits 7:4. The flag and mask registers use bit 0 for wrap, bit 1 for match A and bit 2 for match B. One interrupt line collects the enabled flags.

Top module: `tmr_cpwm`

## Requirements
- R1: The counter advances by one only on cycles where `tick` is high. A write to address 0 loads the counter and takes priority over a tick in the same cycle.
- R2: In free-running mode (control bit 0 = 0), the counter wraps from 0xFF to 0x00 and sets flag bit 0.
- R3: In PWM mode (control bit 0 = 1), a step taken while the counter equals the top register returns the counter to 0x00 and sets flag bit 0. A counter above the top register keeps counting up to 0xFF, then wraps to 0x00 and sets flag bit 0.
- R4: In either mode, flag bit 1 (bit 2) is set when a step brings the counter to the value of compare A (compare B).
- R5: Writing 1 to a flag bit clears that bit, and writing 0 leaves it unchanged. A flag set event in the same cycle wins over the clear.
- R6: `irq` is high exactly when some flag bit is set and its mask bit (same position at address 6) is also set.
- R7: In free-running mode all four PWM outputs are low.
- R8: In PWM mode with dead time 0, once the counter has restarted from 0x00, a channel's true output is high exactly while counter < its compare value. Its inverted output is the complement of the true output.
- R9: With a dead time D (control bits 7:4), each rising edge of the true and inverted outputs comes D counter steps after the level change that causes it. The two outputs of a channel are never high together.
- R10: Each register reads back at its address. Control reads as {dead time, 3'b000, mode}. Flags and mask read in bits 2:0. All registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaler step enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address (write and read) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| pwm_a | output | 1 | Channel A true output |
| pwm_an | output | 1 | Channel A inverted output |
| pwm_b | output | 1 | Channel B true output |
| pwm_bn | output | 1 | Channel B inverted output |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is the dead band under an irregular prescaler. In that state the level changes, the dead-time count and the counter must all advance on the same sparse steps. If the dead-time count ran on the clock instead, the edges would land at the wrong counter value. The stimulus toggles `tick` every other cycle while PWM runs with a nonzero dead time. Compare B is set to 1, so the true pulse is shorter than the dead band and must be suppressed entirely. Every cycle, each output is compared with a window expressed in counter values read through the register port. A second hard case is a counter loaded above the top register, which must run on to 0xFF before it restarts.

// File: rtl/tmr_cpwm_pkg.sv
package tmr_cpwm_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RG_CNT  = 3'd0,
    RG_CMPA = 3'd1,
    RG_CMPB = 3'd2,
    RG_TOP  = 3'd3,
    RG_CTRL = 3'd4,
    RG_FLAG = 3'd5,
    RG_MASK = 3'd6
  } reg_addr_e;

  localparam int unsigned FLG_WRAP = 0;
  localparam int unsigned FLG_MA   = 1;
  localparam int unsigned FLG_MB   = 2;
  localparam int unsigned NFLG     = 3;
  localparam int unsigned NCH      = 2;
endpackage

// File: rtl/tmr_cpwm_count.sv
module tmr_cpwm_count #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         pwm_mode,
  input  logic [W-1:0] top,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_nxt,
  output logic         step,
  output logic         wrap
);
  localparam logic [W-1:0] MAXV = '1;

  logic [W-1:0] cnt_q;
  logic         at_end;

  // a load from the register port suppresses the step in that cycle
  assign step    = tick & ~ld;
  assign at_end  = (cnt_q == MAXV) | (pwm_mode & (cnt_q == top));
  assign cnt_nxt = at_end ? '0 : cnt_q + 1'b1;
  assign wrap    = step & at_end;
  assign cnt     = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (ld)   cnt_q <= ld_val;
    else if (step) cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/tmr_cpwm_chan.sv
module tmr_cpwm_chan #(
  parameter int unsigned W   = 8,
  parameter int unsigned DTW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pwm_mode,
  input  logic           step,
  input  logic [W-1:0]   cnt_nxt,
  input  logic [W-1:0]   cmp,
  input  logic [DTW-1:0] dt,
  output logic           match,
  output logic           out_t,
  output logic           out_n
);
  logic           lvl_q, lvl_d, chg;
  logic [DTW-1:0] band_q;
  logic           band_idle;

  assign match = step & (cnt_nxt == cmp);

  // level rises at restart, falls on match; match wins when cmp is zero
  always_comb begin
    lvl_d = lvl_q;
    if (!pwm_mode)            lvl_d = 1'b0;
    else if (step) begin
      if (cnt_nxt == cmp)     lvl_d = 1'b0;
      else if (cnt_nxt == '0) lvl_d = 1'b1;
    end
  end

  assign chg = lvl_d ^ lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      band_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      if (chg)                      band_q <= dt;
      else if (step && !band_idle)  band_q <= band_q - 1'b1;
    end
  end

  assign band_idle = (band_q == '0);
  assign out_t     = pwm_mode & lvl_q & band_idle;
  assign out_n     = pwm_mode & ~lvl_q & band_idle;
endmodule

// File: rtl/tmr_cpwm.sv
module tmr_cpwm
  import tmr_cpwm_pkg::*;
#(
  parameter int unsigned W   = 8,
  parameter int unsigned DTW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  output logic              pwm_a,
  output logic              pwm_an,
  output logic              pwm_b,
  output logic              pwm_bn,
  output logic              irq
);
  localparam int unsigned PADW = W - DTW - 1;

  logic [W-1:0]    cmp_q [NCH];
  logic [W-1:0]    top_q;
  logic            pwm_q;
  logic [DTW-1:0]  dt_q;
  logic [NFLG-1:0] flags_q, flag_set, flag_clr;
  logic [NFLG-1:0] mask_q;

  logic [W-1:0]    cnt_q, cnt_nxt;
  logic            step, wrap, ld;
  logic [NCH-1:0]  match, o_t, o_n;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input reg_addr_e r);
    return wr_en && (a == r);
  endfunction

  assign ld = hit(addr, RG_CNT);

  tmr_cpwm_count #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pwm_mode(pwm_q), .top(top_q),
    .ld(ld), .ld_val(wdata), .cnt(cnt_q), .cnt_nxt(cnt_nxt),
    .step(step), .wrap(wrap)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tmr_cpwm_chan #(.W(W), .DTW(DTW)) u_ch (
      .clk(clk), .rst_n(rst_n), .pwm_mode(pwm_q), .step(step),
      .cnt_nxt(cnt_nxt), .cmp(cmp_q[c]), .dt(dt_q),
      .match(match[c]), .out_t(o_t[c]), .out_n(o_n[c])
    );
  end

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q[0] <= '0;
      cmp_q[1] <= '0;
      top_q    <= '0;
      pwm_q    <= 1'b0;
      dt_q     <= '0;
      mask_q   <= '0;
    end else begin
      if (hit(addr, RG_CMPA)) cmp_q[0] <= wdata;
      if (hit(addr, RG_CMPB)) cmp_q[1] <= wdata;
      if (hit(addr, RG_TOP))  top_q    <= wdata;
      if (hit(addr, RG_CTRL)) begin
        pwm_q <= wdata[0];
        dt_q  <= wdata[W-1 -: DTW];
      end
      if (hit(addr, RG_MASK)) mask_q <= wdata[NFLG-1:0];
    end
  end

  // flags: events set, write-one clears, set dominates
  always_comb begin
    flag_set           = '0;
    flag_set[FLG_WRAP] = wrap;
    flag_set[FLG_MA]   = match[0];
    flag_set[FLG_MB]   = match[1];
    flag_clr           = hit(addr, RG_FLAG) ? wdata[NFLG-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~flag_clr) | flag_set;
  end

  // read mux
  always_comb begin
    rdata = '0;
    unique case (addr)
      RG_CNT:  rdata = cnt_q;
      RG_CMPA: rdata = cmp_q[0];
      RG_CMPB: rdata = cmp_q[1];
      RG_TOP:  rdata = top_q;
      RG_CTRL: rdata = {dt_q, {PADW{1'b0}}, pwm_q};
      RG_FLAG: rdata = {{(W-NFLG){1'b0}}, flags_q};
      RG_MASK: rdata = {{(W-NFLG){1'b0}}, mask_q};
      default: rdata = '0;
    endcase
  end

  assign irq    = |(flags_q & mask_q);
  assign pwm_a  = o_t[0];
  assign pwm_an = o_n[0];
  assign pwm_b  = o_t[1];
  assign pwm_bn = o_n[1];
endmodule

// File: rtl/tmr_cpwm_chk.sv
module tmr_cpwm_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         wr_en,
  input logic [2:0]   addr,
  input logic [W-1:0] wdata,
  input logic [W-1:0] cnt,
  input logic [W-1:0] top,
  input logic         pwm,
  input logic [2:0]   flags,
  input logic         set_ma,
  input logic         pa,
  input logic         pan,
  input logic         pb,
  input logic         pbn
);
  logic ld_w, flg_w;
  assign ld_w  = wr_en && (addr == 3'd0);
  assign flg_w = wr_en && (addr == 3'd5);

  // R1
  hold_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ld_w) |=> $stable(cnt));

  // R2
  free_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !pwm && !ld_w && cnt == '1) |=> (cnt == '0 && flags[0]));

  // R3
  top_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pwm && !ld_w && cnt == top) |=> (cnt == '0 && flags[0]));

  // R5
  clr_ma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_w && wdata[1] && !set_ma) |=> !flags[1]);

  // R7
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm |-> !(pa || pan || pb || pbn));

  // R9
  gap_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pa && pan));

  // R9
  gap_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pb && pbn));
endmodule

bind tmr_cpwm tmr_cpwm_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .cnt(cnt_q), .top(top_q), .pwm(pwm_q), .flags(flags_q),
  .set_ma(match[0]), .pa(pwm_a), .pan(pwm_an), .pb(pwm_b), .pbn(pwm_bn)
);

// File: tb/tmr_cpwm_tb_top.sv
module tmr_cpwm_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       pwm_a, pwm_an, pwm_b, pwm_bn, irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  tmr_cpwm dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pwm_a(pwm_a), .pwm_an(pwm_an),
    .pwm_b(pwm_b), .pwm_bn(pwm_bn), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      chk("R10 reset value", v, 0);
    end
    chk("R7 outputs at reset", {pwm_a, pwm_an, pwm_b, pwm_bn}, 0);
    chk("R6 irq at reset", irq, 0);
  endtask

  task automatic t_readback();
    logic [7:0] v;
    wr(3'd1, 8'h5A); wr(3'd2, 8'hA5); wr(3'd3, 8'h3C); wr(3'd6, 8'hFF);
    wr(3'd4, 8'hF1);
    rd(3'd1, v); chk("R10 cmp A", v, 8'h5A);
    rd(3'd2, v); chk("R10 cmp B", v, 8'hA5);
    rd(3'd3, v); chk("R10 top", v, 8'h3C);
    step();
    rd(3'd4, v); chk("R10 control", v, 8'hF1);
    rd(3'd6, v); chk("R10 mask", v, 8'h07);
    wr(3'd4, 8'h00); wr(3'd6, 8'h00);
  endtask

  task automatic t_free();
    logic [7:0] v;
    tick = 1'b0;
    wr(3'd0, 8'hFD); wr(3'd5, 8'h07);
    step(); step(); step();
    rd(3'd0, v); chk("R1 hold without tick", v, 8'hFD);
    tick = 1'b1;
    step(); step();
    tick = 1'b0;
    rd(3'd0, v); chk("R1 two steps", v, 8'hFF);
    rd(3'd5, v); chk("R2 no wrap yet", v, 0);
    tick = 1'b1;
    step();
    tick = 1'b0;
    rd(3'd0, v); chk("R2 wrap to zero", v, 0);
    rd(3'd5, v); chk("R2 wrap flag", v, 8'h01);
    tick = 1'b1;
    wr(3'd0, 8'h40);
    tick = 1'b0;
    rd(3'd0, v); chk("R1 load beats tick", v, 8'h40);
    chk("R7 outputs idle free mode", {pwm_a, pwm_an, pwm_b, pwm_bn}, 0);
  endtask

  task automatic t_match();
    logic [7:0] v;
    tick = 1'b0;
    wr(3'd1, 8'h10); wr(3'd2, 8'h20); wr(3'd0, 8'h0E); wr(3'd5, 8'h07);
    tick = 1'b1; step(); tick = 1'b0;
    rd(3'd5, v); chk("R4 no match at 0x0F", v, 0);
    tick = 1'b1; step(); tick = 1'b0;
    rd(3'd5, v); chk("R4 match A", v, 8'h02);
    wr(3'd0, 8'h1F);
    tick = 1'b1; step(); tick = 1'b0;
    rd(3'd5, v); chk("R4 match B", v, 8'h06);
    chk("R7 outputs idle after matches", {pwm_a, pwm_an, pwm_b, pwm_bn}, 0);
  endtask

  task automatic t_flags();
    logic [7:0] v;
    tick = 1'b0;
    wr(3'd6, 8'h00); chk("R6 masked off", irq, 0);
    wr(3'd6, 8'h02); chk("R6 A enabled", irq, 1);
    wr(3'd5, 8'h02);
    rd(3'd5, v); chk("R5 clear A only", v, 8'h04);
    chk("R6 after clear", irq, 0);
    wr(3'd6, 8'h04); chk("R6 B enabled", irq, 1);
    wr(3'd5, 8'h00);
    rd(3'd5, v); chk("R5 zero write keeps", v, 8'h04);
    wr(3'd5, 8'h07);
    rd(3'd5, v); chk("R5 clear all", v, 0);
    wr(3'd0, 8'hFF);
    tick = 1'b1;
    wr(3'd5, 8'h01);
    tick = 1'b0;
    rd(3'd5, v); chk("R5 set wins over clear", v, 8'h01);
    wr(3'd6, 8'h00);
  endtask

  task automatic t_pwm_top();
    logic [7:0] v;
    tick = 1'b0;
    wr(3'd3, 8'h09); wr(3'd1, 8'h03); wr(3'd2, 8'h06);
    wr(3'd0, 8'h00); wr(3'd5, 8'h07); wr(3'd4, 8'h01);
    tick = 1'b1;
    for (int k = 1; k <= 25; k++) begin
      step();
      rd(3'd0, v); chk("R3 count bounded by top", v, k % 10);
      if (k == 9) begin
        rd(3'd5, v); chk("R3 no wrap flag before top", v & 8'h01, 0);
      end
      if (k == 10) begin
        rd(3'd5, v); chk("R3 wrap flag at top", v & 8'h01, 1);
      end
    end
    tick = 1'b0;
    wr(3'd5, 8'h07); wr(3'd0, 8'hFE);
    tick = 1'b1;
    step();
    rd(3'd0, v); chk("R3 above top climbs", v, 8'hFF);
    rd(3'd5, v); chk("R3 no flag at 0xFF", v & 8'h01, 0);
    step();
    rd(3'd0, v); chk("R3 wrap from 0xFF", v, 0);
    rd(3'd5, v); chk("R3 flag from 0xFF", v & 8'h01, 1);
    for (int k = 0; k < 20; k++) begin
      step();
      rd(3'd0, v);
      chk("R8 A true", pwm_a, int'(v < 3));
      chk("R8 A inverted", pwm_an, int'(v >= 3));
      chk("R8 B true", pwm_b, int'(v < 6));
      chk("R8 B inverted", pwm_bn, int'(v >= 6));
    end
    tick = 1'b0;
  endtask

  task automatic t_dead();
    logic [7:0] v;
    tick = 1'b0;
    wr(3'd1, 8'h05); wr(3'd2, 8'h01); wr(3'd4, 8'h21);
    for (int k = 0; k < 30; k++) begin
      tick = k[0];
      step();
    end
    for (int k = 0; k < 40; k++) begin
      tick = k[0];
      step();
      rd(3'd0, v);
      chk("R9 A true window", pwm_a, int'(v >= 2 && v < 5));
      chk("R9 A inverted window", pwm_an, int'(v >= 7));
      chk("R9 B true suppressed", pwm_b, 0);
      chk("R9 B inverted window", pwm_bn, int'(v >= 3));
      chk("R9 no overlap", int'((pwm_a & pwm_an) | (pwm_b & pwm_bn)), 0);
    end
    tick = 1'b0;
    wr(3'd4, 8'h20);
    chk("R7 outputs drop leaving PWM", {pwm_a, pwm_an, pwm_b, pwm_bn}, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    t_reset();
    t_readback();
    t_free();
    t_match();
    t_flags();
    t_pwm_top();
    t_dead();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule